// File: doc/BRIEF.md
# Fixed Off-Time PWM Chopper

This block regulates coil current in two motor phases by chopping. Each phase closes its main low-side switch and keeps it closed until a digital comparator input reports that the sensed current has reached the trip level. The comparator is ignored for a blanking window at the start of every on-period, so the window is also the shortest possible on-time. After a trip the phase opens the main switch for a fixed off-time. During that time the complementary switch is driven for synchronous rectification, with a dead gap where both gates are off at each hand-over.

The off-time follows the phase's current ratio code. High ratios get the longest off-time and low ratios the shortest, so small currents are not chopped away. A ratio code of zero parks the phase with both gates off. In synchronous mode, a trip in either phase starts the off-time of both phases on the same clock edge. This keeps chopping aligned while a motor is held. A global disable drops every gate at once. When the disable is released, each phase restarts with a fresh blanking window. All times are counter reloads derived from the system clock frequency parameter.

Top module: `chop_pwm`

## Requirements
- R1: While rst_ni is low, every main_o and rect_o bit is 0, whatever the other inputs are.
- R2: Each on-period starts with a blanking window of 1.5 µs during which trip_i is ignored, so main_o stays high for at least that long.
- R3: When blank_long_i is 1 as an on-period starts, that on-period uses a 3.0 µs blanking window instead.
- R4: A trip_i seen high after blanking drops main_o at the next clock edge, so the on-time equals the number of cycles until the trip is seen.
- R5: For ratio codes 8 to 15 (4-bit code per phase, phase p at code_i[4p+3:4p]), main_o stays low for 11.5 µs after a trip.
- R6: For ratio codes 4 to 7 the off-time is 8.5 µs, and for codes 1 to 3 it is 7.0 µs.
- R7: rect_o is high during the off-time except for a 0.5 µs dead gap at its start and at its end. main_o and rect_o of one phase are never high together.
- R8: With sync_i high, an accepted trip in one phase also ends the on-period of every other phase at the same edge. With sync_i low, the phases chop independently.
- R9: A phase whose ratio code is 0 keeps main_o and rect_o low.
- R10: dis_i high drives every gate low at the next clock edge. After release, each phase waits one dead gap and then starts an on-period with a full blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dis_i | input | 1 | Global disable, forces all gates off |
| sync_i | input | 1 | Aligns the off-times of all phases |
| blank_long_i | input | 1 | Selects the long blanking window |
| code_i | input | N_PH*CODE_W | Current ratio code per phase |
| trip_i | input | N_PH | Comparator trip per phase, high when current reached the trip level |
| main_o | output | N_PH | Main low-side gate per phase |
| rect_o | output | N_PH | Synchronous-rectification gate per phase |

## Verification
Several rules are checked by assertions on every cycle: the two gates of a phase are never on together, each gate rises only after a cycle with the other gate off, a trip seen inside the blanking window leaves the phase on, and disable, zero code and accepted trips each turn the gates off at the next edge. In synchronous mode, a peer trip must turn off any phase that is on. The absolute lengths of blanking, dead gaps and off-times per code group, the choice between the long and short blanking window, and the restart after disable can only be shown by the bench. It counts gate cycles in scenarios that cover every code group and several trip delays.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP_ON,
    ST_ON,
    ST_GAP_OFF,
    ST_RECT
  } ph_state_e;

  function automatic int ns2cyc(input longint hz, input longint ns);
    return int'((hz * ns) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/chop_offsel.sv
module chop_offsel #(
  parameter int CODE_W  = 4,
  parameter int CNT_W   = 12,
  parameter int OFF_L_C = 1150,
  parameter int OFF_M_C = 850,
  parameter int OFF_S_C = 700
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  off_o,
  output logic              zero_o
);
  localparam logic [CODE_W-1:0] THR_L = CODE_W'(8);
  localparam logic [CODE_W-1:0] THR_M = CODE_W'(4);

  always_comb begin
    zero_o = (code_i == '0);
    if (code_i >= THR_L)      off_o = CNT_W'(OFF_L_C);
    else if (code_i >= THR_M) off_o = CNT_W'(OFF_M_C);
    else                      off_o = CNT_W'(OFF_S_C);
  end
endmodule

// File: rtl/chop_phase.sv
module chop_phase
  import chop_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int CNT_W     = 12,
  parameter int BLANK_C   = 150,
  parameter int BLANK_L_C = 300,
  parameter int DEAD_C    = 50,
  parameter int OFF_L_C   = 1150,
  parameter int OFF_M_C   = 850,
  parameter int OFF_S_C   = 700
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dis_i,
  input  logic              force_i,
  input  logic              blank_long_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              trip_i,
  output logic              trip_ok_o,
  output logic              main_o,
  output logic              rect_o
);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] DEAD_LD  = CNT_W'(DEAD_C - 1);
  localparam logic [CNT_W-1:0] BLK_S_LD = CNT_W'(BLANK_C - 1);
  localparam logic [CNT_W-1:0] BLK_L_LD = CNT_W'(BLANK_L_C - 1);
  localparam logic [CNT_W-1:0] GAPS     = CNT_W'(2 * DEAD_C + 1);

  ph_state_e        st_q;
  logic [CNT_W-1:0] cnt_q, off_q, off_sel, rect_ld;
  logic             zero, cnt_done;

  chop_offsel #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W),
    .OFF_L_C(OFF_L_C),
    .OFF_M_C(OFF_M_C),
    .OFF_S_C(OFF_S_C)
  ) u_offsel (
    .code_i(code_i),
    .off_o (off_sel),
    .zero_o(zero)
  );

  assign cnt_done  = (cnt_q == '0);
  assign rect_ld   = off_q - GAPS;
  assign trip_ok_o = (st_q == ST_ON) && cnt_done && trip_i && !dis_i && !zero;
  assign main_o    = (st_q == ST_ON);
  assign rect_o    = (st_q == ST_RECT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      off_q <= '0;
    end else if (dis_i || zero) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_q  <= ST_GAP_ON;
          cnt_q <= DEAD_LD;
        end
        ST_GAP_ON: begin
          if (cnt_done) begin
            st_q  <= ST_ON;
            cnt_q <= blank_long_i ? BLK_L_LD : BLK_S_LD;
          end else cnt_q <= cnt_q - ONE;
        end
        ST_ON: begin
          if (trip_ok_o || force_i) begin
            st_q  <= ST_GAP_OFF;
            cnt_q <= DEAD_LD;
            off_q <= off_sel;
          end else if (!cnt_done) cnt_q <= cnt_q - ONE;
        end
        ST_GAP_OFF: begin
          if (cnt_done) begin
            st_q  <= ST_RECT;
            cnt_q <= rect_ld;
          end else cnt_q <= cnt_q - ONE;
        end
        ST_RECT: begin
          if (cnt_done) begin
            st_q  <= ST_GAP_ON;
            cnt_q <= DEAD_LD;
          end else cnt_q <= cnt_q - ONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_reset_off_R1: assert property (@(posedge clk_i) !rst_ni |-> !main_o && !rect_o);

  assert_blank_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ON && !cnt_done && !force_i && !dis_i && !zero) |=> main_o);

  assert_trip_ends_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_ok_o |=> !main_o);

  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_o && rect_o));

  assert_gap_before_main_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_o) |-> $past(!rect_o));

  assert_gap_before_rect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rect_o) |-> $past(!main_o));

  assert_zero_code_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero |=> !main_o && !rect_o);

  assert_disable_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !main_o && !rect_o);
endmodule

// File: rtl/chop_pwm.sv
module chop_pwm
  import chop_pkg::*;
#(
  parameter int CLK_HZ        = 100_000_000,
  parameter int N_PH          = 2,
  parameter int CODE_W        = 4,
  parameter int BLANK_NS      = 1500,
  parameter int BLANK_LONG_NS = 3000,
  parameter int DEAD_NS       = 500,
  parameter int OFF_LONG_NS   = 11500,
  parameter int OFF_MID_NS    = 8500,
  parameter int OFF_SHORT_NS  = 7000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dis_i,
  input  logic                     sync_i,
  input  logic                     blank_long_i,
  input  logic [N_PH*CODE_W-1:0]   code_i,
  input  logic [N_PH-1:0]          trip_i,
  output logic [N_PH-1:0]          main_o,
  output logic [N_PH-1:0]          rect_o
);
  localparam int BLANK_C   = ns2cyc(CLK_HZ, BLANK_NS);
  localparam int BLANK_L_C = ns2cyc(CLK_HZ, BLANK_LONG_NS);
  localparam int DEAD_C    = ns2cyc(CLK_HZ, DEAD_NS);
  localparam int OFF_L_C   = ns2cyc(CLK_HZ, OFF_LONG_NS);
  localparam int OFF_M_C   = ns2cyc(CLK_HZ, OFF_MID_NS);
  localparam int OFF_S_C   = ns2cyc(CLK_HZ, OFF_SHORT_NS);
  localparam int CNT_W     = $clog2(OFF_L_C + BLANK_L_C + 1);

  logic [N_PH-1:0] trip_ok, force_off;

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    localparam logic [N_PH-1:0] SELF = N_PH'(1) << p;

    assign force_off[p] = sync_i && |(trip_ok & ~SELF);

    chop_phase #(
      .CODE_W   (CODE_W),
      .CNT_W    (CNT_W),
      .BLANK_C  (BLANK_C),
      .BLANK_L_C(BLANK_L_C),
      .DEAD_C   (DEAD_C),
      .OFF_L_C  (OFF_L_C),
      .OFF_M_C  (OFF_M_C),
      .OFF_S_C  (OFF_S_C)
    ) u_ph (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .dis_i       (dis_i),
      .force_i     (force_off[p]),
      .blank_long_i(blank_long_i),
      .code_i      (code_i[p*CODE_W +: CODE_W]),
      .trip_i      (trip_i[p]),
      .trip_ok_o   (trip_ok[p]),
      .main_o      (main_o[p]),
      .rect_o      (rect_o[p])
    );

    assert_sync_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_i && |(trip_ok & ~SELF) && main_o[p]) |=> !main_o[p]);
  end
endmodule

// File: tb/tb_chop_pwm.sv
module tb_chop_pwm;
  localparam int CLK_HZ  = 20_000_000;
  localparam int CPU     = CLK_HZ / 1_000_000;   // cycles per microsecond
  localparam int BLANK   = (1500 * CPU) / 1000;
  localparam int DEAD    = (500 * CPU) / 1000;
  localparam int OFF_L   = (11500 * CPU) / 1000;
  localparam int OFF_M   = (8500 * CPU) / 1000;
  localparam int OFF_S   = (7000 * CPU) / 1000;
  localparam int NV      = 7;

  // {code, long blank, trip delay, expected on, expected off}
  localparam logic [28:0] VEC [NV] = '{
    {4'h8, 1'b0, 8'd1,   8'd30,  8'd230},
    {4'hF, 1'b1, 8'd1,   8'd60,  8'd230},
    {4'h4, 1'b0, 8'd45,  8'd45,  8'd170},
    {4'h6, 1'b1, 8'd20,  8'd60,  8'd170},
    {4'h2, 1'b0, 8'd31,  8'd31,  8'd140},
    {4'h1, 1'b0, 8'd1,   8'd30,  8'd140},
    {4'hA, 1'b0, 8'd100, 8'd100, 8'd230}
  };

  logic       clk = 1'b0;
  logic       rst_ni, dis, sync, blong;
  logic [7:0] code;
  logic [1:0] trip, main_g, rect_g;
  logic       b_seen = 1'b0;
  int         errs = 0, checks = 0;

  always #2 clk = ~clk;

  chop_pwm #(.CLK_HZ(CLK_HZ)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .dis_i(dis), .sync_i(sync),
    .blank_long_i(blong), .code_i(code), .trip_i(trip),
    .main_o(main_g), .rect_o(rect_g)
  );

  always @(negedge clk) if (rst_ni && (main_g[1] || rect_g[1])) b_seen <= 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int d, output int on, output int off,
                         output int rect, output int gap);
    bit seen;
    trip[0] = 1'b1;
    while (main_g[0]) @(negedge clk);
    trip[0] = 1'b0;
    while (!main_g[0]) @(negedge clk);
    on = 0;
    while (main_g[0]) begin
      on++;
      if (on >= d) trip[0] = 1'b1;
      @(negedge clk);
    end
    trip[0] = 1'b0;
    off = 0; rect = 0; gap = 0; seen = 0;
    while (!main_g[0]) begin
      off++;
      if (rect_g[0]) begin rect++; seen = 1; end
      else if (!seen) gap++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int on, off, rect, gap, n;
    bit prevb;
    rst_ni = 1'b0; dis = 1'b0; sync = 1'b0; blong = 1'b0;
    code = 8'h08; trip = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 main in reset", int'(main_g), 0);
    chk("R1 rect in reset", int'(rect_g), 0);
    rst_ni = 1'b1;

    // table walk, phase B parked at code 0
    for (int i = 0; i < NV; i++) begin
      code  = {4'h0, VEC[i][28:25]};
      blong = VEC[i][24];
      measure(int'(VEC[i][23:16]), on, off, rect, gap);
      chk($sformatf("R2 R3 R4 on-time vec%0d", i), on, int'(VEC[i][15:8]));
      chk($sformatf("R5 R6 off-time vec%0d", i), off, int'(VEC[i][7:0]));
      chk($sformatf("R7 rect length vec%0d", i), rect, int'(VEC[i][7:0]) - 2 * DEAD);
      chk($sformatf("R7 leading gap vec%0d", i), gap, DEAD);
    end
    chk("R9 zero-code phase stayed off", int'(b_seen), 0);
    blong = 1'b0;
    code  = 8'h08;

    // disable during on-period, then fresh restart (R10)
    while (!main_g[0]) @(negedge clk);
    dis = 1'b1;
    @(negedge clk);
    chk("R10 gates off after disable (on)", int'({main_g, rect_g}), 0);
    dis = 1'b0;
    n = 0;
    @(negedge clk);
    while (!main_g[0]) begin n++; @(negedge clk); end
    chk("R10 gap after release", n, DEAD);
    trip[0] = 1'b1;
    on = 0;
    while (main_g[0]) begin on++; @(negedge clk); end
    trip[0] = 1'b0;
    chk("R10 fresh blanking after release", on, BLANK);

    // disable during rectification
    while (!rect_g[0]) @(negedge clk);
    dis = 1'b1;
    @(negedge clk);
    chk("R10 gates off after disable (rect)", int'({main_g, rect_g}), 0);
    dis = 1'b0;

    // synchronous mode (R8)
    code = 8'hCC; sync = 1'b1;
    @(negedge clk);
    dis = 1'b1; @(negedge clk); dis = 1'b0;
    trip[0] = 1'b1;
    while (!main_g[0]) @(negedge clk);
    prevb = 0;
    while (main_g[0]) begin prevb = main_g[1]; @(negedge clk); end
    trip[0] = 1'b0;
    chk("R8 peer on before trip", int'(prevb), 1);
    chk("R8 peer off with trip", int'(main_g[1]), 0);
    while (!rect_g[0]) @(negedge clk);
    chk("R8 peer rect aligned", int'(rect_g[1]), 1);

    // independent mode (R8)
    sync = 1'b0;
    @(negedge clk);
    dis = 1'b1; @(negedge clk); dis = 1'b0;
    trip[0] = 1'b1;
    while (!main_g[0]) @(negedge clk);
    while (main_g[0]) @(negedge clk);
    trip[0] = 1'b0;
    chk("R8 peer stays on without sync", int'(main_g[1]), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule